// File: doc/BRIEF.md
# SPI Slave Header Decoder with Register-Bus Master

This block is the serial front end of a register-mapped peripheral. An external controller selects it with an active-low chip select and talks SPI mode 3 (clock idle high, data launched on the falling edge, sampled on the rising edge, most significant bit first). Each transfer opens with a two- or three-byte header that carries a byte address and a three-bit command. The block then runs a read or write data phase against a simple byte-wide register bus on the system clock side.

While the header is shifting in, the block returns live interrupt status bytes on MISO, so the controller gets the pending events with every access at no extra cost. A command value can widen the address from 13 to 16 bits by asking for a third header byte. Read and write data phases step through consecutive addresses. Read data is fetched one byte ahead, so it is ready before its first bit is due. A read variant inserts one dummy byte for slow register files.

SCLK, chip select and MOSI are taken to be synchronous to the system clock and are oversampled by it. Each SCLK phase must last at least 4 system clock cycles.

Top module: `spiHdrSlave`

## Requirements
- R1: MOSI is sampled on each SCLK rising edge seen while csN is low. MISO changes after each SCLK falling edge. Bytes are MSB first in both directions. Each SCLK high and low phase lasts at least 4 clk cycles.
- R2: During header byte k, MISO returns irqStatus[8k+7:8k]. Byte 0 gives bits 7:0 and byte 1 gives bits 15:8. Byte 2 gives bits 23:16 and exists only when the address is extended.
- R3: Header byte 0 gives address bits 12:5. Header byte 1 bits 7:3 give address bits 4:0, and bits 2:0 give the command. Without extension, address bits 15:13 are zero.
- R4: Command 110 in byte 1 requests a third header byte. Its bits 7:5 give address bits 15:13 and its bits 2:0 give the command that takes effect. Its bits 4:3 are ignored. A second 110 in byte 2 is handled as a no-operation.
- R5: Command 100 (write) turns every later byte into one single-cycle busWr pulse. The pulse carries that byte on busWdata, at the header address plus the byte index. MISO stays low during write data.
- R6: Command 010 (read) returns on MISO the bytes at the header address, plus 0, 1, 2 and so on. busRdata is taken in the cycle after busRd. A transfer of n data bytes issues exactly n+1 busRd pulses, because one fetch runs ahead.
- R7: Command 011 (read with wait byte) sends MISO low for one dummy byte after the header. It then returns data from the header address onward, again with n+1 busRd pulses for n data bytes.
- R8: Commands 000, 001, 101 and 111 cause no busRd or busWr pulse, and MISO stays low for the rest of the transfer.
- R9: While csN is high, MISO is low and no bus pulse is issued. Raising csN at any point discards a partial byte and restarts header decoding for the next transfer.
- R10: After reset, miso, busRd and busWr are low.
- R11: busRd and busWr are never high together, and each is high for one clk cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI clock, idle high |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| irqStatus | input | 24 | Interrupt status, three bytes, returned during the header |
| busAddr | output | 16 | Register bus byte address |
| busRd | output | 1 | Read pulse, data expected on busRdata one cycle later |
| busWr | output | 1 | Write pulse |
| busWdata | output | 8 | Write data |
| busRdata | input | 8 | Read data |

## Verification
Transfers are tried with every command encoding, with two-byte and three-byte headers, and with data lengths of one to four bytes. This separates the path the command decode takes, how address bits are assembled, and whether the address steps per byte. Addresses with bits 15:13 set in a two-byte header, and junk in the ignored bits of byte 2, show whether extension is honoured only when requested. The read data pattern depends on every address bit, so an off-by-one in the prefetch or a wrong first address shows up at once. A transfer cut off in the middle of a byte, followed by a normal write, shows whether the framing restarts cleanly.

// File: rtl/spiHdrPkg.sv
package spiHdrPkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 16;
  localparam int IRQ_BYTES = 3;
  localparam int IRQ_W     = IRQ_BYTES * BYTE_W;
  localparam int CNT_W     = $clog2(BYTE_W);
  localparam int CMD_W     = 3;
  localparam int LO_W      = BYTE_W - CMD_W;          // low address bits in byte 1
  localparam int EXT_W     = ADDR_W - BYTE_W - LO_W;  // high address bits in byte 2

  localparam logic [CMD_W-1:0] CMD_RD  = 3'b010;
  localparam logic [CMD_W-1:0] CMD_RDW = 3'b011;
  localparam logic [CMD_W-1:0] CMD_WR  = 3'b100;
  localparam logic [CMD_W-1:0] CMD_EXT = 3'b110;

  typedef enum logic [2:0] {
    ST_HDR0, ST_HDR1, ST_HDR2, ST_READ, ST_WRITE, ST_SKIP
  } hdrState_t;

  typedef enum logic [1:0] {
    NX_KEEP, NX_IRQ1, NX_IRQ2, NX_ZERO
  } nextSel_t;

  typedef struct packed {
    logic     idle;
    logic     shiftIn;
    logic     byteStart;
    logic     shiftOut;
    logic     latchHi;
    logic     latchLo;
    logic     setAddr2;
    logic     setAddr3;
    logic     startRead;
    logic     fetchNext;
    logic     writeByte;
    nextSel_t nextSel;
  } strobes_t;
endpackage

// File: rtl/spiHdrCtrl.sv
module spiHdrCtrl
  import spiHdrPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             csN,
  input  logic [CMD_W-1:0] cmdBits,
  output strobes_t         stb
);
  logic             sclkQ;
  logic [CNT_W-1:0] bitCnt;
  hdrState_t        state, nextState;
  logic             rise, fall, byteDone, dispatch;

  assign rise     = !csN && sclk && !sclkQ;
  assign fall     = !csN && !sclk && sclkQ;
  assign byteDone = rise && (bitCnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b1;
      bitCnt <= '0;
      state  <= ST_HDR0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        bitCnt <= '0;
        state  <= ST_HDR0;
      end else begin
        if (rise) bitCnt <= bitCnt + 1'b1;
        if (byteDone) state <= nextState;
      end
    end
  end

  always_comb begin
    stb           = '0;
    stb.nextSel   = NX_KEEP;
    nextState     = state;
    dispatch      = 1'b0;
    stb.idle      = csN;
    stb.shiftIn   = rise;
    stb.byteStart = fall && (bitCnt == '0);
    stb.shiftOut  = fall && (bitCnt != '0);
    stb.fetchNext = stb.byteStart && (state == ST_READ);
    if (byteDone) begin
      case (state)
        ST_HDR0: begin
          stb.latchHi = 1'b1;
          stb.nextSel = NX_IRQ1;
          nextState   = ST_HDR1;
        end
        ST_HDR1: begin
          stb.latchLo = 1'b1;
          if (cmdBits == CMD_EXT) begin
            stb.nextSel = NX_IRQ2;
            nextState   = ST_HDR2;
          end else begin
            stb.setAddr2 = 1'b1;
            dispatch     = 1'b1;
          end
        end
        ST_HDR2: begin
          stb.setAddr3 = 1'b1;
          dispatch     = 1'b1;
        end
        ST_WRITE: stb.writeByte = 1'b1;
        default: ;
      endcase
      if (dispatch) begin
        case (cmdBits)
          CMD_RD: begin
            stb.startRead = 1'b1;
            nextState     = ST_READ;
          end
          CMD_RDW: begin
            stb.nextSel = NX_ZERO;
            nextState   = ST_READ;
          end
          CMD_WR: begin
            stb.nextSel = NX_ZERO;
            nextState   = ST_WRITE;
          end
          default: begin
            stb.nextSel = NX_ZERO;
            nextState   = ST_SKIP;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/spiHdrDatapath.sv
module spiHdrDatapath
  import spiHdrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              mosi,
  input  logic [IRQ_W-1:0]  irqStatus,
  input  logic [BYTE_W-1:0] busRdata,
  output logic [BYTE_W-1:0] rxNext,
  output logic              miso,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [BYTE_W-1:0] busWdata
);
  logic [BYTE_W-2:0] rxShift;
  logic [BYTE_W-1:0] hiByte, nextTx, txShift;
  logic [LO_W-1:0]   loBits;
  logic [ADDR_W-1:0] curAddr, hdrAddr;
  logic              rdPending;

  assign rxNext = {rxShift, mosi};

  always_comb begin
    if (stb.setAddr3)
      hdrAddr = {rxNext[BYTE_W-1 -: EXT_W], hiByte, loBits};
    else
      hdrAddr = {{EXT_W{1'b0}}, hiByte, rxNext[BYTE_W-1 -: LO_W]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      hiByte    <= '0;
      loBits    <= '0;
      nextTx    <= '0;
      txShift   <= '0;
      curAddr   <= '0;
      rdPending <= 1'b0;
      miso      <= 1'b0;
      busAddr   <= '0;
      busRd     <= 1'b0;
      busWr     <= 1'b0;
      busWdata  <= '0;
    end else begin
      busRd     <= 1'b0;
      busWr     <= 1'b0;
      rdPending <= busRd;
      if (rdPending) nextTx <= busRdata;
      if (stb.idle) begin
        miso    <= 1'b0;
        rxShift <= '0;
        nextTx  <= irqStatus[BYTE_W-1:0];
      end else begin
        if (stb.shiftIn) rxShift <= rxNext[BYTE_W-2:0];
        if (stb.byteStart) begin
          miso    <= nextTx[BYTE_W-1];
          txShift <= {nextTx[BYTE_W-2:0], 1'b0};
        end
        if (stb.shiftOut) begin
          miso    <= txShift[BYTE_W-1];
          txShift <= {txShift[BYTE_W-2:0], 1'b0};
        end
        if (stb.latchHi) hiByte <= rxNext;
        if (stb.latchLo) loBits <= rxNext[BYTE_W-1 -: LO_W];
        case (stb.nextSel)
          NX_IRQ1: nextTx <= irqStatus[BYTE_W +: BYTE_W];
          NX_IRQ2: nextTx <= irqStatus[2*BYTE_W +: BYTE_W];
          NX_ZERO: nextTx <= '0;
          default: ;
        endcase
        if (stb.setAddr2 || stb.setAddr3)
          curAddr <= stb.startRead ? hdrAddr + 1'b1 : hdrAddr;
        if (stb.startRead) begin
          busRd   <= 1'b1;
          busAddr <= hdrAddr;
        end
        if (stb.fetchNext) begin
          busRd   <= 1'b1;
          busAddr <= curAddr;
          curAddr <= curAddr + 1'b1;
        end
        if (stb.writeByte) begin
          busWr    <= 1'b1;
          busAddr  <= curAddr;
          busWdata <= rxNext;
          curAddr  <= curAddr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spiHdrSlave.sv
module spiHdrSlave
  import spiHdrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  input  logic [IRQ_W-1:0]  irqStatus,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [BYTE_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] busRdata
);
  strobes_t          stb;
  logic [BYTE_W-1:0] rxNext;

  spiHdrCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclk    (sclk),
    .csN     (csN),
    .cmdBits (rxNext[CMD_W-1:0]),
    .stb     (stb)
  );

  spiHdrDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .mosi      (mosi),
    .irqStatus (irqStatus),
    .busRdata  (busRdata),
    .rxNext    (rxNext),
    .miso      (miso),
    .busAddr   (busAddr),
    .busRd     (busRd),
    .busWr     (busWr),
    .busWdata  (busWdata)
  );
endmodule

// File: rtl/spiHdrSlaveChk.sv
module spiHdrSlaveChk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic miso,
  input logic busRd,
  input logic busWr
);
  // R9
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !miso);

  // R9
  idle_no_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> (!busRd && !busWr));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> !busRd);

  // R11
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> !busWr);
endmodule

bind spiHdrSlave spiHdrSlaveChk u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .csN   (csN),
  .miso  (miso),
  .busRd (busRd),
  .busWr (busWr)
);

// File: tb/tb_spiHdrSlave.sv
module tb_spiHdrSlave;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclk = 1'b1;
  logic        csN = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [23:0] irqStatus = '0;
  logic [15:0] busAddr;
  logic        busRd, busWr;
  logic [7:0]  busWdata;
  logic [7:0]  busRdata = '0;

  int checks = 0;
  int errors = 0;
  int rdN = 0;
  int wrN = 0;
  int overlapN = 0;
  bit done = 0;
  logic [15:0] rdA [256];
  logic [15:0] wrA [256];
  logic [7:0]  wrD [256];

  always #5 clk = ~clk;

  spiHdrSlave dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .irqStatus(irqStatus), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic logic [7:0] memFn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // 0 none, 1 read, 2 read with wait byte, 3 write
  function automatic int kindOf(input logic [2:0] c);
    case (c)
      3'b010:  return 1;
      3'b011:  return 2;
      3'b100:  return 3;
      default: return 0;
    endcase
  endfunction

  // register bus model: read data one cycle after busRd
  always @(posedge clk) begin
    if (busRd) begin
      busRdata <= memFn(busAddr);
      rdA[rdN % 256] = busAddr;
      rdN++;
    end
    if (busWr) begin
      wrA[wrN % 256] = busAddr;
      wrD[wrN % 256] = busWdata;
      wrN++;
    end
    if (busRd && busWr) overlapN++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk);
      sclk = 1'b0;
      mosi = tx[b];
      repeat (5) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic runXfer(input bit ext, input logic [2:0] cmd, input logic [15:0] addr,
                         input int n, input logic [1:0] junk);
    logic [7:0]  hdr [3];
    logic [7:0]  wdat [8];
    logic [7:0]  rx;
    logic [15:0] ea, expA;
    int kind, rd0, wr0, hlen;
    string reqA;
    ea   = ext ? addr : {3'b000, addr[12:0]};
    kind = kindOf(cmd);
    reqA = ext ? "R4 address" : "R3 address";
    hdr[0] = addr[12:5];
    hdr[1] = {addr[4:0], (ext ? 3'b110 : cmd)};
    hdr[2] = {addr[15:13], junk, cmd};
    hlen = ext ? 3 : 2;
    @(negedge clk);
    irqStatus = 24'($urandom);
    rd0 = rdN;
    wr0 = wrN;
    @(negedge clk);
    csN = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < hlen; i++) begin
      sendByte(hdr[i], rx);
      chk(rx == irqStatus[8*i +: 8], "R2 header status (R1 bit order)", rx, irqStatus[8*i +: 8]);
    end
    if (kind == 2) begin
      sendByte(8'($urandom), rx);
      chk(rx == 8'h00, "R7 dummy byte low", rx, 0);
    end
    for (int i = 0; i < n; i++) begin
      wdat[i] = 8'($urandom);
      sendByte((kind == 3) ? wdat[i] : 8'hA5, rx);
      expA = ea + 16'(i);
      case (kind)
        1:       chk(rx == memFn(expA), "R6 read data", rx, memFn(expA));
        2:       chk(rx == memFn(expA), "R7 read data after wait", rx, memFn(expA));
        3:       chk(rx == 8'h00, "R5 miso low on write", rx, 0);
        default: chk(rx == 8'h00, "R8 miso low on ignored command", rx, 0);
      endcase
    end
    repeat (3) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    chk(miso == 1'b0, "R9 miso low while deselected", miso, 0);
    case (kind)
      3: begin
        chk(wrN - wr0 == n, "R5 write count", wrN - wr0, n);
        chk(rdN == rd0, "R5 no reads on write", rdN - rd0, 0);
        for (int i = 0; i < n; i++) begin
          expA = ea + 16'(i);
          chk(wrA[(wr0 + i) % 256] == expA, reqA, wrA[(wr0 + i) % 256], expA);
          chk(wrD[(wr0 + i) % 256] == wdat[i], "R5 write data", wrD[(wr0 + i) % 256], wdat[i]);
        end
      end
      1, 2: begin
        chk(rdN - rd0 == n + 1, (kind == 1) ? "R6 fetch count" : "R7 fetch count", rdN - rd0, n + 1);
        chk(rdA[rd0 % 256] == ea, reqA, rdA[rd0 % 256], ea);
        chk(wrN == wr0, "R6 no writes on read", wrN - wr0, 0);
      end
      default: begin
        chk(rdN == rd0, "R8 no reads", rdN - rd0, 0);
        chk(wrN == wr0, "R8 no writes", wrN - wr0, 0);
      end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    logic [2:0] cmdList [7];
    int rd0, wr0;
    int unsigned seedVal;
    seedVal = $urandom(32'd20240611);
    cmdList = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b111};
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(miso == 1'b0, "R10 miso after reset", miso, 0);
    chk(busRd == 1'b0, "R10 busRd after reset", busRd, 0);
    chk(busWr == 1'b0, "R10 busWr after reset", busWr, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // directed corner cases
    runXfer(1'b0, 3'b010, 16'hFABC, 3, 2'b00);   // R3: bits 15:13 dropped
    runXfer(1'b0, 3'b100, 16'h1FFF, 2, 2'b00);   // R5 at top of 13-bit space
    runXfer(1'b1, 3'b100, 16'hE123, 3, 2'b11);   // R4 junk bits ignored
    runXfer(1'b1, 3'b011, 16'hA0FE, 4, 2'b01);   // R7 across a byte carry
    runXfer(1'b0, 3'b011, 16'h0005, 1, 2'b00);   // R7 single byte
    runXfer(1'b0, 3'b000, 16'h0100, 2, 2'b00);   // R8 no-op
    runXfer(1'b0, 3'b101, 16'h0200, 2, 2'b00);   // R8 reserved
    runXfer(1'b1, 3'b110, 16'h4321, 2, 2'b10);   // R4 double extension ignored
    runXfer(1'b1, 3'b111, 16'h7777, 1, 2'b00);   // R8 reserved after extension

    // R9 abort in the middle of header byte 1
    rd0 = rdN;
    wr0 = wrN;
    @(negedge clk);
    csN = 1'b0;
    repeat (3) @(negedge clk);
    sendByte(8'hFF, rx);
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      sclk = 1'b0;
      mosi = 1'b1;
      repeat (5) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    csN = 1'b1;
    repeat (4) @(negedge clk);
    chk(miso == 1'b0, "R9 miso low after abort", miso, 0);
    chk(rdN == rd0 && wrN == wr0, "R9 no bus access on abort", (rdN - rd0) + (wrN - wr0), 0);
    runXfer(1'b0, 3'b100, 16'h0042, 2, 2'b00);   // R9 fresh header after abort

    // constrained random transfers
    for (int t = 0; t < 30; t++) begin
      runXfer(1'($urandom), cmdList[$urandom % 7], 16'($urandom),
              1 + int'($urandom % 4), 2'($urandom));
    end

    chk(overlapN == 0, "R11 busRd and busWr overlap", overlapN, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule